// File: doc/BRIEF.md
# Deferred-Update Window Configuration Bank

This block stores the configuration of five display overlay windows in two copies. Software writes always land in a staging ("shadow") copy. The copy the pixel datapath sees (the "active" copy) is loaded from the staging copy only on a vsync pulse. A window can be frozen with a hold bit. While it is frozen, vsync leaves its active copy untouched, so a set of related register writes is applied all at once.

The write port takes a window number, a register index and a data word. Each window has its own small state machine with three states:

- SYNCED: the active copy equals the staging copy.
- DIRTY: staging holds data not yet applied.
- HELD: the hold bit is set.

Transitions:

- SYNCED goes to DIRTY on a staging write, and to HELD on a guard write with hold=1.
- DIRTY goes to SYNCED on vsync, which copies staging to active. It goes to HELD on a guard write with hold=1.
- HELD goes to DIRTY on a guard write with hold=0.

A staging write has priority over vsync in the next-state choice. A guard write with hold=1 has priority over both.

The intended sequence is to set hold, write the window registers, then in one guard write clear hold and set the DMA channel enable. Readback returns staging values. A per-window active output shows the active copy at a selected index.

Register indices:

| Index | Content | Windows |
|---|---|---|
| 0 | control | all |
| 1 | base | all |
| 2 | extent | all |
| 3 | stride | all |
| 4 | origin | all |
| 5 | corner | all |
| 6 | size register on window 0, blend on the others | all |
| 7 | size | windows 1 and 2 only |
| 8 | key mode | windows 1 to 4 |
| 9 | key value | windows 1 to 4 |
| 10 | guard: bit 0 hold, bit 1 channel enable; takes effect at once | all |

Top module: `vsb_shadow_bank`

## Requirements
- R1: After reset, every staging and active register reads 0, and all hold and channel-enable bits are 0.
- R2: A staging write is visible on rd_data from the cycle after the write edge. The active copy does not change until a vsync.
- R3: A vsync on a window that is not held copies every staging register of that window into its active copy. The copied values appear on act_data after that clock edge. Active values change at no other time.
- R4: While a window's hold bit is set, vsync does not change its active copy. The first vsync after hold is cleared applies all staged values.
- R5: If the guard write that clears hold falls in the same cycle as vsync, that vsync does not copy. The copy happens at the following vsync.
- R6: If a staging write and vsync fall in the same cycle on an unheld window, the active copy takes the value from before the write. The new value is applied at the next vsync.
- R7: A write to index 10 sets hold from data bit 0 and channel enable from data bit 1 at once. Index 10 reads back {chan_en, hold} in bits [1:0]. The protect and chan_en ports show these bits.
- R8: Window 0 has no registers at indices 8 and 9; writes there are ignored and read 0 (staging and active). Index 6 of window 0 is its size register and holds data.
- R9: Index 7 is stored only for windows 1 and 2. Writes to index 7 of windows 0, 3 and 4 are ignored and read 0.
- R10: Writes with window number 5 or above, or with register index 11 or above, change no register. Reads of such addresses return 0.
- R11: A write or hold affects only the addressed window. Other windows keep their staging data and continue to take vsync copies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_win | input | 3 | Window number of the write |
| wr_idx | input | 4 | Register index of the write |
| wr_data | input | 32 | Write data |
| vsync | input | 1 | One-cycle frame-boundary pulse |
| rd_win | input | 3 | Window number for readback |
| rd_idx | input | 4 | Register index for readback |
| rd_data | output | 32 | Staging value (or guard bits) at rd_win/rd_idx |
| act_idx | input | 4 | Register index shown on every window's active output |
| act_data | output | 5x32 | Active value at act_idx, one word per window |
| protect | output | 5 | Hold bit per window |
| chan_en | output | 5 | DMA channel enable per window |

## Verification
The two functions that can collide are the vsync copy and a register write to the same window. The write may be a staging write or the guard write that releases hold. The bench drives wr_en and vsync high on the same clock edge in both forms. It then reads the active output before any further vsync, expecting the pre-write value or no copy at all. After one more vsync pulse it expects the new value to be applied.

// File: rtl/vsb_pkg.sv
`timescale 1ns/1ps
package vsb_pkg;

    localparam int IDX_W    = 4;
    localparam int IDX_SPAN = 2 ** IDX_W;
    localparam int NUM_SREG = 10;

    localparam int IDX_CTRL    = 0;
    localparam int IDX_BASE    = 1;
    localparam int IDX_EXTENT  = 2;
    localparam int IDX_STRIDE  = 3;
    localparam int IDX_ORIGIN  = 4;
    localparam int IDX_CORNER  = 5;
    localparam int IDX_BLEND   = 6;   // size register on window 0
    localparam int IDX_AREA    = 7;
    localparam int IDX_KEYMODE = 8;
    localparam int IDX_KEYVAL  = 9;
    localparam int IDX_GUARD   = 10;

    localparam int GUARD_HOLD_BIT = 0;
    localparam int GUARD_CHAN_BIT = 1;

    typedef enum logic [1:0] {
        ST_SYNCED = 2'd0,
        ST_DIRTY  = 2'd1,
        ST_HELD   = 2'd2
    } slot_st_e;

    function automatic logic [IDX_SPAN-1:0] present_mask(input int win);
        logic [IDX_SPAN-1:0] m;
        m = '0;
        for (int i = IDX_CTRL; i <= IDX_CORNER; i++) m[i] = 1'b1;
        m[IDX_BLEND] = 1'b1;
        if (win == 1 || win == 2) m[IDX_AREA] = 1'b1;
        if (win != 0) begin
            m[IDX_KEYMODE] = 1'b1;
            m[IDX_KEYVAL]  = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/vsb_wr_decode.sv
`timescale 1ns/1ps
module vsb_wr_decode #(
    parameter int NUM_WIN = 5,
    parameter int WIN_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [WIN_W-1:0]   wr_win,
    output logic [NUM_WIN-1:0] hit
);

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_hit
        assign hit[w] = wr_en && (wr_win == WIN_W'(w));
    end

    // R11
    hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

endmodule

// File: rtl/vsb_win_slot.sv
`timescale 1ns/1ps
module vsb_win_slot
    import vsb_pkg::*;
#(
    parameter int WIN_ID = 0,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              vsync,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [IDX_W-1:0]  act_idx,
    output logic [DATA_W-1:0] rd_val,
    output logic [DATA_W-1:0] act_val,
    output logic              protect,
    output logic              chan_en
);

    localparam logic [IDX_SPAN-1:0] PMASK = present_mask(WIN_ID);

    slot_st_e st_q, st_d;
    logic     chan_q;
    logic     guard_wr, shadow_wr, copy_en, hold_req;

    logic [NUM_SREG-1:0][DATA_W-1:0] shadow_w;
    logic [NUM_SREG-1:0][DATA_W-1:0] active_w;

    assign guard_wr  = hit && (wr_idx == IDX_W'(IDX_GUARD));
    assign shadow_wr = hit && PMASK[wr_idx];
    assign hold_req  = wr_data[GUARD_HOLD_BIT];
    assign copy_en   = vsync && (st_q == ST_DIRTY);

    // next-state choice
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_SYNCED: begin
                if (guard_wr && hold_req) st_d = ST_HELD;
                else if (shadow_wr)       st_d = ST_DIRTY;
            end
            ST_DIRTY: begin
                if (guard_wr && hold_req) st_d = ST_HELD;
                else if (shadow_wr)       st_d = ST_DIRTY;
                else if (vsync)           st_d = ST_SYNCED;
            end
            ST_HELD: begin
                if (guard_wr && !hold_req) st_d = ST_DIRTY;
            end
            default: st_d = ST_SYNCED;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_SYNCED;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        chan_q <= 1'b0;
        else if (guard_wr) chan_q <= wr_data[GUARD_CHAN_BIT];
    end

    // outputs
    always_comb begin
        protect = (st_q == ST_HELD);
        chan_en = chan_q;
    end

    for (genvar i = 0; i < NUM_SREG; i++) begin : g_reg
        if (PMASK[i]) begin : g_live
            logic [DATA_W-1:0] sh_q, ac_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sh_q <= '0;
                    ac_q <= '0;
                end else begin
                    if (shadow_wr && (wr_idx == IDX_W'(i))) sh_q <= wr_data;
                    if (copy_en)                            ac_q <= sh_q;
                end
            end
            assign shadow_w[i] = sh_q;
            assign active_w[i] = ac_q;
        end else begin : g_absent
            assign shadow_w[i] = '0;
            assign active_w[i] = '0;
        end
    end

    always_comb begin
        rd_val = '0;
        if (rd_idx == IDX_W'(IDX_GUARD)) begin
            rd_val[GUARD_HOLD_BIT] = (st_q == ST_HELD);
            rd_val[GUARD_CHAN_BIT] = chan_q;
        end else begin
            for (int i = 0; i < NUM_SREG; i++)
                if (rd_idx == IDX_W'(i)) rd_val = shadow_w[i];
        end
    end

    always_comb begin
        act_val = '0;
        for (int i = 0; i < NUM_SREG; i++)
            if (act_idx == IDX_W'(i)) act_val = active_w[i];
    end

    // R4
    held_no_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HELD) |=> $stable(active_w));

    // R3
    act_vsync_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vsync |=> $stable(active_w));

    // R6
    copy_takes_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync && st_q == ST_DIRTY) |=> (active_w == $past(shadow_w)));

    // R8
    absent_idx_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !PMASK[wr_idx] && wr_idx != IDX_W'(IDX_GUARD)) |=> $stable(shadow_w));

    // R7
    chan_guard_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !guard_wr |=> $stable(chan_en));

endmodule

// File: rtl/vsb_rd_mux.sv
`timescale 1ns/1ps
module vsb_rd_mux #(
    parameter int NUM_WIN = 5,
    parameter int WIN_W   = 3,
    parameter int DATA_W  = 32
) (
    input  logic [WIN_W-1:0]               sel,
    input  logic [NUM_WIN-1:0][DATA_W-1:0] slot_rd,
    output logic [DATA_W-1:0]              rd_data
);

    always_comb begin
        rd_data = '0;
        for (int w = 0; w < NUM_WIN; w++)
            if (sel == WIN_W'(w)) rd_data = slot_rd[w];
    end

endmodule

// File: rtl/vsb_shadow_bank.sv
`timescale 1ns/1ps
module vsb_shadow_bank
    import vsb_pkg::*;
#(
    parameter  int NUM_WIN = 5,
    parameter  int DATA_W  = 32,
    localparam int WIN_W   = $clog2(NUM_WIN)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [WIN_W-1:0]              wr_win,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic                          vsync,
    input  logic [WIN_W-1:0]              rd_win,
    input  logic [IDX_W-1:0]              rd_idx,
    output logic [DATA_W-1:0]             rd_data,
    input  logic [IDX_W-1:0]              act_idx,
    output logic [NUM_WIN-1:0][DATA_W-1:0] act_data,
    output logic [NUM_WIN-1:0]            protect,
    output logic [NUM_WIN-1:0]            chan_en
);

    logic [NUM_WIN-1:0]             hit;
    logic [NUM_WIN-1:0][DATA_W-1:0] slot_rd;

    vsb_wr_decode #(.NUM_WIN(NUM_WIN), .WIN_W(WIN_W)) u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_win (wr_win),
        .hit    (hit)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        vsb_win_slot #(.WIN_ID(w), .DATA_W(DATA_W)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .hit     (hit[w]),
            .wr_idx  (wr_idx),
            .wr_data (wr_data),
            .vsync   (vsync),
            .rd_idx  (rd_idx),
            .act_idx (act_idx),
            .rd_val  (slot_rd[w]),
            .act_val (act_data[w]),
            .protect (protect[w]),
            .chan_en (chan_en[w])
        );
    end

    vsb_rd_mux #(.NUM_WIN(NUM_WIN), .WIN_W(WIN_W), .DATA_W(DATA_W)) u_rd (
        .sel     (rd_win),
        .slot_rd (slot_rd),
        .rd_data (rd_data)
    );

    // R10
    oob_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_win >= WIN_W'(NUM_WIN)) |=> ($stable(protect) && $stable(chan_en)));

endmodule

// File: tb/tb_vsb_shadow_bank.sv
`timescale 1ns/1ps
module tb_vsb_shadow_bank;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [2:0]       wr_win = '0;
    logic [3:0]       wr_idx = '0;
    logic [31:0]      wr_data = '0;
    logic             vsync = 1'b0;
    logic [2:0]       rd_win = '0;
    logic [3:0]       rd_idx = '0;
    logic [31:0]      rd_data;
    logic [3:0]       act_idx = '0;
    logic [4:0][31:0] act_data;
    logic [4:0]       protect;
    logic [4:0]       chan_en;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    bit busy = 0;

    bit          q_act[$];
    int          q_win[$];
    int          q_idx[$];
    logic [31:0] q_exp[$];
    string       q_tag[$];

    always #2.5 clk = ~clk;

    vsb_shadow_bank dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_win(wr_win), .wr_idx(wr_idx),
        .wr_data(wr_data), .vsync(vsync), .rd_win(rd_win), .rd_idx(rd_idx),
        .rd_data(rd_data), .act_idx(act_idx), .act_data(act_data),
        .protect(protect), .chan_en(chan_en)
    );

    function automatic void chk(logic [31:0] act, logic [31:0] exp, string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endfunction

    // scoreboard driver side
    task automatic exp_rd(int w, int i, logic [31:0] v, string tag);
        q_act.push_back(1'b0); q_win.push_back(w); q_idx.push_back(i);
        q_exp.push_back(v); q_tag.push_back(tag);
    endtask

    task automatic exp_act(int w, int i, logic [31:0] v, string tag);
        q_act.push_back(1'b1); q_win.push_back(w); q_idx.push_back(i);
        q_exp.push_back(v); q_tag.push_back(tag);
    endtask

    task automatic drain();
        while (q_exp.size() != 0 || busy) #0.1;
        @(negedge clk);
    endtask

    // monitor: pops expected items and compares against the design
    initial begin
        forever begin
            while (q_exp.size() == 0) #0.1;
            begin
                bit          a;
                int          w, i;
                logic [31:0] e, got;
                string       t;
                busy = 1;
                a = q_act.pop_front(); w = q_win.pop_front(); i = q_idx.pop_front();
                e = q_exp.pop_front(); t = q_tag.pop_front();
                if (a) begin
                    act_idx = 4'(i);
                    #0.2;
                    got = act_data[3'(w)];
                end else begin
                    rd_win = 3'(w);
                    rd_idx = 4'(i);
                    #0.2;
                    got = rd_data;
                end
                chk(got, e, t);
                busy = 0;
            end
        end
    end

    task automatic cyc(bit we, int w, int i, logic [31:0] d, bit vs);
        @(negedge clk);
        wr_en = we; wr_win = 3'(w); wr_idx = 4'(i); wr_data = d; vsync = vs;
        @(negedge clk);
        wr_en = 1'b0; vsync = 1'b0;
    endtask

    task automatic wr(int w, int i, logic [31:0] d); cyc(1'b1, w, i, d, 1'b0); endtask
    task automatic vs();                              cyc(1'b0, 0, 0, '0, 1'b1); endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int w = 0; w < 5; w++) begin
            for (int i = 0; i <= 10; i++) exp_rd(w, i, 32'h0, "R1 staging");
            for (int i = 0; i < 10; i++)  exp_act(w, i, 32'h0, "R1 active");
        end
        drain();
        chk(32'(protect), 32'h0, "R1 protect");
        chk(32'(chan_en), 32'h0, "R1 chan_en");

        // R2 staging write, active untouched
        wr(1, 1, 32'hA1A1_0001);
        exp_rd(1, 1, 32'hA1A1_0001, "R2 readback");
        exp_act(1, 1, 32'h0, "R2 active before vsync");
        drain();

        // R3 vsync copy
        vs();
        exp_act(1, 1, 32'hA1A1_0001, "R3 copy");
        drain();

        // R11 other windows unaffected
        wr(2, 1, 32'hB2B2_0002);
        exp_rd(1, 1, 32'hA1A1_0001, "R11 w1 kept");
        exp_rd(2, 1, 32'hB2B2_0002, "R11 w2 written");
        exp_rd(3, 1, 32'h0, "R11 w3 untouched");
        drain();
        vs();
        exp_act(2, 1, 32'hB2B2_0002, "R3 w2 copy");
        exp_act(3, 1, 32'h0, "R11 w3 active");
        drain();

        // R4 / R7 hold on window 3
        wr(3, 10, 32'h1);
        exp_rd(3, 10, 32'h1, "R7 guard readback hold");
        drain();
        chk(32'(protect), 32'h08, "R7 protect port");
        wr(3, 4, 32'hC3C3_0004);
        wr(3, 5, 32'hC3C3_0005);
        wr(2, 0, 32'hD2D2_0000);
        vs();
        exp_act(3, 4, 32'h0, "R4 held no copy");
        exp_act(2, 0, 32'hD2D2_0000, "R11 unheld w2 still copies");
        drain();
        wr(3, 10, 32'h2);
        exp_rd(3, 10, 32'h2, "R7 guard readback chan");
        exp_act(3, 4, 32'h0, "R4 no copy before vsync");
        drain();
        chk(32'(protect), 32'h00, "R7 protect cleared");
        chk(32'(chan_en), 32'h08, "R7 chan_en port");
        vs();
        exp_act(3, 4, 32'hC3C3_0004, "R4 first vsync after release");
        exp_act(3, 5, 32'hC3C3_0005, "R4 first vsync after release");
        drain();

        // R5 release and vsync in the same cycle
        wr(4, 10, 32'h1);
        wr(4, 2, 32'hE4E4_0002);
        cyc(1'b1, 4, 10, 32'h2, 1'b1);
        exp_act(4, 2, 32'h0, "R5 same-cycle release no copy");
        exp_rd(4, 10, 32'h2, "R5 guard after release");
        drain();
        vs();
        exp_act(4, 2, 32'hE4E4_0002, "R5 copy at next vsync");
        drain();

        // R6 staging write and vsync in the same cycle
        wr(1, 3, 32'hF1F1_0001);
        cyc(1'b1, 1, 3, 32'hF1F1_0002, 1'b1);
        exp_act(1, 3, 32'hF1F1_0001, "R6 old value applied");
        exp_rd(1, 3, 32'hF1F1_0002, "R6 new value staged");
        drain();
        vs();
        exp_act(1, 3, 32'hF1F1_0002, "R6 new value at next vsync");
        drain();

        // R8 window 0 missing key registers, size at index 6
        wr(0, 8, 32'h1234_5678);
        wr(0, 9, 32'h8765_4321);
        wr(0, 6, 32'h0000_5A00);
        exp_rd(0, 8, 32'h0, "R8 w0 idx8 ignored");
        exp_rd(0, 9, 32'h0, "R8 w0 idx9 ignored");
        exp_rd(0, 6, 32'h0000_5A00, "R8 w0 size at idx6");
        drain();
        vs();
        exp_act(0, 8, 32'h0, "R8 w0 idx8 active");
        exp_act(0, 6, 32'h0000_5A00, "R8 w0 size active");
        drain();

        // R9 size index 7 only on windows 1 and 2
        for (int w = 0; w < 5; w++) wr(w, 7, 32'h7700_0000 | 32'(w));
        exp_rd(0, 7, 32'h0, "R9 w0 idx7");
        exp_rd(1, 7, 32'h7700_0001, "R9 w1 idx7");
        exp_rd(2, 7, 32'h7700_0002, "R9 w2 idx7");
        exp_rd(3, 7, 32'h0, "R9 w3 idx7");
        exp_rd(4, 7, 32'h0, "R9 w4 idx7");
        drain();
        vs();
        exp_act(2, 7, 32'h7700_0002, "R9 w2 idx7 active");
        exp_act(4, 7, 32'h0, "R9 w4 idx7 active");
        drain();

        // R10 out-of-range addresses
        wr(5, 1, 32'hDEAD_0005);
        wr(7, 10, 32'h3);
        wr(1, 11, 32'hDEAD_000B);
        wr(1, 15, 32'hDEAD_000F);
        exp_rd(0, 1, 32'h0, "R10 w0 idx1");
        exp_rd(1, 1, 32'hA1A1_0001, "R10 w1 idx1");
        exp_rd(2, 1, 32'hB2B2_0002, "R10 w2 idx1");
        exp_rd(3, 1, 32'h0, "R10 w3 idx1");
        exp_rd(4, 1, 32'h0, "R10 w4 idx1");
        exp_rd(1, 11, 32'h0, "R10 idx11 read");
        exp_rd(5, 1, 32'h0, "R10 w5 read");
        drain();
        chk(32'(protect), 32'h00, "R10 protect unchanged");
        chk(32'(chan_en), 32'h18, "R10 chan_en unchanged");

        done = 1;
        summary();
        $finish;
    end

endmodule